// File: doc/BRIEF.md
# Phase-Window Lock Detector

This block judges whether a phase-locked loop is holding lock by looking at one phase-error sample per phase-detector comparison. Each sample is a signed count of fine time units (the edge-timing offset between reference and feedback). The sample arrives on a valid/ready stream. The block drives two plain status outputs. `lol` reports loss of lock and follows every comparison, so it can chatter while the loop settles. `locked` asserts only after a run of consecutive comparisons that all stay inside a tight window.

Two separate thresholds are used. A wide threshold, by default 32 units (4 ns at 125 ps per unit), marks a phase transient as loss of lock. A tight window, by default 16 units (2 ns), qualifies stable lock once it holds for `RUN_LEN` samples in a row (default 8). The decisions assume frequent comparisons. If no sample arrives for `GAP_MAX` clock cycles, the comparison rate is treated as unsupported and the block falls back to loss of lock. `LOCK_WIN` must be smaller than `LOL_THRESH`.

Stream rules: `err_ready` is held high at all times. The block never applies back-pressure, and it consumes a sample in every cycle in which `err_valid` is high. A sender may therefore ignore `err_ready`.

Top module: `phase_lock_detect`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `lol` is 1, `locked` is 0, and the in-window run count is zero.
- R2: On a valid sample with |err| >= LOL_THRESH (default 32), `lol` becomes 1 on that clock edge. On a valid sample with |err| < LOL_THRESH, `lol` becomes 0. The output is re-evaluated on every sample.
- R3: `locked` becomes 1 on the edge of the RUN_LEN-th consecutive valid sample with |err| <= LOCK_WIN (default 16 units, run of 8), and not before.
- R4: A valid sample with |err| > LOCK_WIN clears the run count and drives `locked` to 0 on that edge. After that, a full new run of RUN_LEN in-window samples is needed.
- R5: The run count saturates at RUN_LEN, so `locked` stays 1 for as long as in-window samples continue.
- R6: Magnitude is the absolute value, so a negative error acts like its positive counterpart. The most negative code, -2^(ERR_W-1), always counts as loss of lock and as outside the window.
- R7: Cycles with `err_valid` low leave `lol` and `locked` unchanged, whatever `err_data` carries, except for the case in R8.
- R8: After GAP_MAX consecutive cycles without a valid sample (default 64), `lol` is set to 1, `locked` is cleared and the run count is reset on the edge that ends the GAP_MAX-th idle cycle.
- R9: `err_ready` is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | A phase-error sample is present |
| err_ready | output | 1 | Always 1; the block never back-pressures |
| err_data | input | ERR_W | Signed phase error in fine time units |
| lol | output | 1 | Loss of lock, updated per sample |
| locked | output | 1 | Qualified stable lock |

## Verification
The bench targets the threshold edges. A sample of exactly 32 must raise loss of lock and one of exactly 16 must still count as in-window. A design with an off-by-one comparison would fail to flag the transient, or would break a valid run. It checks that `locked` rises on the eighth in-window sample and not on the seventh. It also checks that one out-of-window sample forces a full new run; a counter that only decremented or held its value would re-lock too early. The most negative input, an idle gap carrying a large error on the bus, and a starvation gap of exactly 63 and then 64 cycles are driven on their own. These catch a design that wraps the absolute value, acts on invalid data, or misses the rate fallback by one cycle.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Classification of one phase-error sample against both thresholds.
  typedef struct packed {
    logic big;     // at or beyond the loss-of-lock threshold
    logic in_win;  // inside the tight stable-lock window
  } sample_cls_t;

endpackage

// File: rtl/lockdet_classify.sv
module lockdet_classify
  import lockdet_pkg::*;
#(
  parameter int ERR_W      = 12,
  parameter int LOL_THRESH = 32,
  parameter int LOCK_WIN   = 16
) (
  input  logic [ERR_W-1:0] err,
  output sample_cls_t      cls
);

  localparam logic [ERR_W-1:0] LOL_T   = ERR_W'(LOL_THRESH);
  localparam logic [ERR_W-1:0] WIN_T   = ERR_W'(LOCK_WIN);
  localparam logic [ERR_W-1:0] MIN_NEG = {1'b1, {(ERR_W-1){1'b0}}};

  logic [ERR_W-1:0] mag;
  logic             is_min_neg;

  always_comb begin
    is_min_neg = (err == MIN_NEG);
    mag        = err[ERR_W-1] ? (~err + 1'b1) : err;
    cls.big    = is_min_neg || (mag >= LOL_T);
    cls.in_win = !is_min_neg && (mag <= WIN_T);
  end

endmodule

// File: rtl/lockdet_run.sv
module lockdet_run
  import lockdet_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_vld,
  input  logic sample_in_win,
  input  logic force_clear,
  output logic locked_q
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] run_nxt;

  always_comb begin
    run_nxt = run_cnt;
    if (sample_vld) begin
      if (!sample_in_win)          run_nxt = '0;
      else if (run_cnt != RUN_TOP) run_nxt = run_cnt + 1'b1;
    end else if (force_clear) begin
      run_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      locked_q <= 1'b0;
    end else begin
      run_cnt  <= run_nxt;
      locked_q <= (run_nxt == RUN_TOP);
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_TOP); // R5

  AST_OUTWIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && !sample_in_win |=> !locked_q && (run_cnt == '0)); // R4

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && sample_vld && sample_in_win |=> locked_q); // R5

endmodule

// File: rtl/lockdet_starve.sv
module lockdet_starve #(
  parameter int GAP_MAX = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_vld,
  output logic starve
);

  localparam int GAP_W = $clog2(GAP_MAX + 1);
  localparam logic [GAP_W-1:0] GAP_TOP  = GAP_W'(GAP_MAX);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_MAX - 1);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  gap_cnt <= '0;
    else if (sample_vld)         gap_cnt <= '0;
    else if (gap_cnt != GAP_TOP) gap_cnt <= gap_cnt + 1'b1;
  end

  assign starve = !sample_vld && (gap_cnt == GAP_LAST);

  AST_GAP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> (gap_cnt == '0)); // R8

endmodule

// File: rtl/phase_lock_detect.sv
module phase_lock_detect
  import lockdet_pkg::*;
#(
  parameter int ERR_W      = 12,
  parameter int LOL_THRESH = 32,
  parameter int LOCK_WIN   = 16,
  parameter int RUN_LEN    = 8,
  parameter int GAP_MAX    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  output logic             err_ready,
  input  logic [ERR_W-1:0] err_data,
  output logic             lol,
  output logic             locked
);

  sample_cls_t cls;
  logic        starve;

  assign err_ready = 1'b1;

  lockdet_classify #(
    .ERR_W(ERR_W), .LOL_THRESH(LOL_THRESH), .LOCK_WIN(LOCK_WIN)
  ) u_classify (
    .err (err_data),
    .cls (cls)
  );

  lockdet_starve #(.GAP_MAX(GAP_MAX)) u_starve (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (err_valid),
    .starve     (starve)
  );

  lockdet_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_vld    (err_valid),
    .sample_in_win (cls.in_win),
    .force_clear   (starve),
    .locked_q      (locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         lol <= 1'b1;
    else if (err_valid) lol <= cls.big;
    else if (starve)    lol <= 1'b1;
  end

  AST_LOL_ON_BIG: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && cls.big |=> lol); // R2

  AST_LOL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !cls.big |=> !lol); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid && !starve |=> $stable(lol) && $stable(locked)); // R7

  AST_STARVE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> lol && !locked); // R8

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(lol && locked)); // R3

  AST_LOCK_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(err_valid)); // R3

endmodule

// File: tb/test_phase_lock_detect.sv
module test_phase_lock_detect;

  localparam int ERR_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             err_valid = 1'b0;
  logic             err_ready;
  logic [ERR_W-1:0] err_data = '0;
  logic             lol;
  logic             locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  phase_lock_detect #(
    .ERR_W(ERR_W), .LOL_THRESH(32), .LOCK_WIN(16), .RUN_LEN(8), .GAP_MAX(64)
  ) i_phase_lock_detect (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_data(err_data), .lol(lol), .locked(locked)
  );

  typedef struct packed {
    logic signed [ERR_W-1:0] err;
    logic                    lol;
    logic                    lk;
  } vec_t;

  // Back-to-back valid samples: err, expected lol, expected locked after the edge.
  localparam vec_t VEC [23] = '{
    '{12'sd40,  1'b1, 1'b0},  // R2 large
    '{-12'sd32, 1'b1, 1'b0},  // R2 exactly at threshold, R6 negative
    '{12'sd31,  1'b0, 1'b0},  // R2 just below
    '{12'sd16,  1'b0, 1'b0},  // R3 window edge, run 1
    '{-12'sd16, 1'b0, 1'b0},  // R6 run 2
    '{12'sd0,   1'b0, 1'b0},
    '{12'sd5,   1'b0, 1'b0},
    '{-12'sd3,  1'b0, 1'b0},
    '{12'sd10,  1'b0, 1'b0},
    '{12'sd1,   1'b0, 1'b0},  // run 7: R3 not yet
    '{12'sd2,   1'b0, 1'b1},  // run 8: R3 locked
    '{-12'sd15, 1'b0, 1'b1},  // R5 holds
    '{12'sd17,  1'b0, 1'b0},  // R4 out of window
    '{12'sd8,   1'b0, 1'b0},
    '{12'sd33,  1'b1, 1'b0},  // R2 transient
    '{12'sd0,   1'b0, 1'b0},
    '{12'sd0,   1'b0, 1'b0},
    '{12'sd0,   1'b0, 1'b0},
    '{12'sd0,   1'b0, 1'b0},
    '{12'sd0,   1'b0, 1'b0},
    '{12'sd0,   1'b0, 1'b0},
    '{12'sd0,   1'b0, 1'b0},  // run 7 after R4 reset
    '{12'sd0,   1'b0, 1'b1}   // run 8
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic sample(input logic v, input logic [ERR_W-1:0] e);
    err_valid = v;
    err_data  = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_to_lock();
    for (int k = 0; k < 8; k++) sample(1'b1, 12'd0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R9 ready in reset", err_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R1 lol at reset", lol, 1'b1);
    check("R1 locked at reset", locked, 1'b0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < 23; i++) begin
      sample(1'b1, VEC[i].err);
      check($sformatf("R2 vec%0d lol", i), lol, VEC[i].lol);
      check($sformatf("R3 vec%0d locked", i), locked, VEC[i].lk);
    end
    check("R9 ready", err_ready, 1'b1);

    // R7: idle cycles with a large error on the bus change nothing
    for (int k = 0; k < 10; k++) sample(1'b0, 12'd500);
    check("R7 idle lol", lol, 1'b0);
    check("R7 idle locked", locked, 1'b1);

    // R6: most negative code is loss of lock and out of window
    sample(1'b1, 12'h800);
    check("R6 minneg lol", lol, 1'b1);
    check("R6 minneg locked", locked, 1'b0);

    // R8: starvation after exactly 64 idle cycles
    run_to_lock();
    check("R8 pre lock", locked, 1'b1);
    for (int k = 0; k < 63; k++) sample(1'b0, 12'd0);
    check("R8 63 idle locked", locked, 1'b1);
    check("R8 63 idle lol", lol, 1'b0);
    sample(1'b0, 12'd0);
    check("R8 64 idle lol", lol, 1'b1);
    check("R8 64 idle locked", locked, 1'b0);
    sample(1'b1, 12'd0);
    check("R8 run cleared lol", lol, 1'b0);
    check("R8 run cleared locked", locked, 1'b0);

    // R1: reset in the middle of lock
    run_to_lock();
    check("R5 relocked", locked, 1'b1);
    rst_n = 1'b0;
    sample(1'b1, 12'd0);
    check("R1 mid reset lol", lol, 1'b1);
    check("R1 mid reset locked", locked, 1'b0);
    check("R9 ready in reset", err_ready, 1'b1);
    rst_n = 1'b1;
    for (int k = 0; k < 7; k++) sample(1'b1, 12'd0);
    check("R1 count cleared", locked, 1'b0);
    sample(1'b1, 12'd0);
    check("R3 lock after reset", locked, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule